// File: doc/BRIEF.md
# Dither Phase Timing Sequencer

This block produces the timing for a loop that corrects line drop in a power cable by small measurement steps. A free-running oscillator tick drives it, and it divides that tick into dither periods. The length of a period is chosen by a 3-bit code. Each period has two equal halves. In the first half the supply regulates its output voltage. In the second half it regulates a current that is 10% below the value just measured. Single-tick capture strobes mark when the high voltage, the output current, the low voltage and the voltage delta are valid for the analog track/hold circuits outside the block.

Three conditions gate the sequence. A run level must be high before anything happens, and dropping it returns the block to an idle, voltage-regulating state. An overvoltage level blocks correction while it is high. Starting after run rises, or after overvoltage clears, raises a one-clock soft-correct request, so that correction ramps in from zero. An optional spread mode inserts a short pseudo-random gap of 0 to 3 ticks before each new period. A divided-by-two copy of the tick is given out, so that an external switching regulator can run on the same clock.

States of the controller:
- `ST_IDLE`: run is low.
- `ST_OVBLK`: overvoltage block.
- `ST_START`: one clock in which the soft-correct request is issued.
- `ST_VREG`: first half of a period, voltage regulation.
- `ST_IREG`: second half of a period, reduced-current regulation.
- `ST_JIT`: spread gap before the next period.

Transitions of the controller:
- Any state goes to `ST_IDLE` when run is low.
- Any other state goes to `ST_OVBLK` when overvoltage is high and run is high. This transition has lower priority than the one to `ST_IDLE`.
- `ST_IDLE` and `ST_OVBLK` go to `ST_START` once run is high and overvoltage is low.
- `ST_START` goes to `ST_VREG` on the next clock.
- `ST_VREG` goes to `ST_IREG` on the last tick of the half.
- `ST_IREG` goes to `ST_JIT` on its last tick when the gap is non-zero, and to `ST_VREG` otherwise.
- `ST_JIT` goes to `ST_VREG` once its gap ticks have elapsed.

Top module: `dither_phase_seq`

## Requirements
- R1: A dither period lasts (8 << div_sel) oscillator ticks, not counting spread gaps. Each half is (4 << code) ticks, and a tick is a clock in which osc_tick is high.
- R2: During the first half of a period mode_cur is 0 (voltage regulation). During the second half mode_cur is 1 (current regulation at 90%). In every other state mode_cur is 0.
- R3: trk_vhi and trk_iout are high together for exactly the last tick interval of the first half, and they are low at all other times.
- R4: trk_vlo is high for the second-to-last tick interval of the second half, and trk_dv is high for the last tick interval of the second half. The voltage delta is therefore the final capture of the period.
- R5: div_sel is taken only when a period starts: on leaving ST_START, and on the last tick of a second half. A change made in the middle of a period alters the next period, not the current one.
- R6: With spread_en low, periods follow each other with no gap. With spread_en high, each new period is preceded by a gap of g = min(lfsr[1:0], (8 << code)/8) ticks, evaluated at the end of the previous period. During the gap mode_cur is 0 and all strobes are low.
- R7: The jitter source is a 16-bit register with seed 0xACE1. It shifts left once at the end of every period, and the new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R8: While run_ok is low, all strobes, mode_cur and soft_req are 0, and ticks are ignored. Dropping run_ok restarts the period counter and reseeds the jitter source.
- R9: soft_req is a one-clock pulse on the clock after run_ok rises, or after ovp falls while run_ok is high. The first period starts on the clock after the pulse and has no gap.
- R10: While ovp is high (with run_ok high), mode_cur is 0 and no strobe is raised.
- R11: sync_clk is 0 after reset and toggles on every tick, whatever the state.
- R12: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| div_sel | input | 3 | Period code, period = 8 << code ticks |
| spread_en | input | 1 | Enables pseudo-random gap before each period |
| run_ok | input | 1 | Run comparator level, high enables sequencing |
| ovp | input | 1 | Overvoltage comparator level, high blocks correction |
| mode_cur | output | 1 | 0 = regulate voltage, 1 = regulate reduced current |
| trk_vhi | output | 1 | Capture strobe for high output voltage |
| trk_iout | output | 1 | Capture strobe for output current |
| trk_vlo | output | 1 | Capture strobe for low output voltage |
| trk_dv | output | 1 | Capture strobe for voltage delta |
| soft_req | output | 1 | One-clock soft-correct restart request |
| sync_clk | output | 1 | Tick divided by two, for regulator synchronisation |

## Verification
The bench keeps the default widths (3-bit code, 16-bit jitter source, 2-bit gap). It uses a tick every four clocks, so that strobe timing is seen across whole tick intervals. It runs codes 0, 1, 2, 3 and 7. This covers the smallest half of 4 ticks, where the low-voltage and delta strobes fall in adjacent intervals, and the largest half of 512 ticks. Spread runs at codes 0, 1 and 2 reach all three gap caps (1, 2 and 3 ticks), and a second spread run after a run drop shows that the jitter source is reseeded.

// File: rtl/dps_pkg.sv
package dps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OVBLK,
        ST_START,
        ST_JIT,
        ST_VREG,
        ST_IREG
    } dps_state_e;
endpackage

// File: rtl/dps_lfsr.sv
module dps_lfsr #(
    parameter int          LFSR_W = 16,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [LFSR_W-1:0] value
);
    logic [LFSR_W-1:0] lfsr_q;
    logic              fb;

    assign fb    = ^(lfsr_q & TAPS[LFSR_W-1:0]);
    assign value = lfsr_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lfsr_q <= SEED[LFSR_W-1:0];
        end else if (step) begin
            lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R7
endmodule

// File: rtl/dps_sync_div.sv
module dps_sync_div (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic sync_clk
);
    logic sync_q;

    assign sync_clk = sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else if (tick) begin
            sync_q <= ~sync_q;
        end
    end

    AST_SYNC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (sync_clk != $past(sync_clk))); // R11
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sync_clk)); // R11
endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
    import dps_pkg::*;
#(
    parameter int DIV_W     = 3,
    parameter int BASE_LOG2 = 3,
    parameter int JIT_W     = 2,
    parameter int CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             spread_en,
    input  logic             run_ok,
    input  logic             ovp,
    input  logic [JIT_W-1:0] jit_raw,
    output logic             lfsr_step,
    output logic             mode_cur,
    output logic             trk_vhi,
    output logic             trk_iout,
    output logic             trk_vlo,
    output logic             trk_dv,
    output logic             soft_req
);
    localparam logic [CNT_W-1:0] HALF_INIT = CNT_W'(1) << (BASE_LOG2 - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO       = CNT_W'(2);
    localparam logic [JIT_W-1:0] JONE      = JIT_W'(1);
    localparam logic [JIT_W-1:0] JMAX      = '1;

    dps_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [JIT_W-1:0] jit_q, jit_d;
    logic [DIV_W-1:0] div_q, div_d;
    logic [CNT_W-1:0] half;
    logic             last, prelast;
    logic [JIT_W-1:0] cap, jit_val;

    assign half    = HALF_INIT << div_q;
    assign last    = (cnt_q == half - ONE);
    assign prelast = (cnt_q == half - TWO);

    always_comb begin
        if (div_sel >= DIV_W'(JIT_W)) begin
            cap = JMAX;
        end else begin
            cap = JIT_W'(JONE << div_sel);
        end
        if (!spread_en) begin
            jit_val = '0;
        end else if (jit_raw > cap) begin
            jit_val = cap;
        end else begin
            jit_val = jit_raw;
        end
    end

    assign lfsr_step = (st_q == ST_IREG) && osc_tick && last && run_ok && !ovp;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        jit_d = jit_q;
        div_d = div_q;
        if (!run_ok) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
            jit_d = '0;
            div_d = div_sel;
        end else if (ovp) begin
            st_d  = ST_OVBLK;
            cnt_d = '0;
            jit_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_OVBLK: st_d = ST_START;
                ST_START: begin
                    st_d  = ST_VREG;
                    cnt_d = '0;
                    div_d = div_sel;
                end
                ST_VREG: if (osc_tick) begin
                    if (last) begin
                        st_d  = ST_IREG;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_IREG: if (osc_tick) begin
                    if (last) begin
                        cnt_d = '0;
                        div_d = div_sel;
                        if (jit_val != '0) begin
                            st_d  = ST_JIT;
                            jit_d = jit_val;
                        end else begin
                            st_d = ST_VREG;
                        end
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_JIT: if (osc_tick) begin
                    if (jit_q == JONE) begin
                        st_d = ST_VREG;
                    end else begin
                        jit_d = jit_q - JONE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            jit_q <= '0;
            div_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            jit_q <= jit_d;
            div_q <= div_d;
        end
    end

    always_comb begin
        mode_cur = 1'b0;
        trk_vhi  = 1'b0;
        trk_iout = 1'b0;
        trk_vlo  = 1'b0;
        trk_dv   = 1'b0;
        soft_req = 1'b0;
        unique case (st_q)
            ST_START: soft_req = 1'b1;
            ST_VREG: begin
                trk_vhi  = last;
                trk_iout = last;
            end
            ST_IREG: begin
                mode_cur = 1'b1;
                trk_vlo  = prelast;
                trk_dv   = last;
            end
            default: ;
        endcase
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_VREG || st_q == ST_IREG) |-> (cnt_q < half)); // R1
    AST_VHI_TO_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_vhi && osc_tick && run_ok && !ovp) |=> mode_cur); // R2
    AST_VLO_THEN_DV: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_vlo && osc_tick && run_ok && !ovp) |=> trk_dv); // R4
    AST_DV_ENDS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_dv && osc_tick && run_ok && !ovp) |=> !mode_cur); // R4
    AST_RUN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> !mode_cur && !trk_vhi && !trk_vlo && !trk_dv && !soft_req); // R8
    AST_OV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && ovp) |=> !mode_cur && !trk_vhi && !trk_iout && !trk_vlo && !trk_dv); // R10
    AST_SOFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_req |=> !soft_req); // R9
endmodule

// File: rtl/dither_phase_seq.sv
module dither_phase_seq #(
    parameter int DIV_W     = 3,
    parameter int BASE_LOG2 = 3,
    parameter int LFSR_W    = 16,
    parameter int JIT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             spread_en,
    input  logic             run_ok,
    input  logic             ovp,
    output logic             mode_cur,
    output logic             trk_vhi,
    output logic             trk_iout,
    output logic             trk_vlo,
    output logic             trk_dv,
    output logic             soft_req,
    output logic             sync_clk
);
    localparam int CNT_W = BASE_LOG2 + (1 << DIV_W) - 1;

    logic [LFSR_W-1:0] lfsr_val;
    logic              lfsr_step;

    dps_lfsr #(
        .LFSR_W (LFSR_W)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!run_ok),
        .step  (lfsr_step),
        .value (lfsr_val)
    );

    dps_fsm #(
        .DIV_W     (DIV_W),
        .BASE_LOG2 (BASE_LOG2),
        .JIT_W     (JIT_W),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .div_sel   (div_sel),
        .spread_en (spread_en),
        .run_ok    (run_ok),
        .ovp       (ovp),
        .jit_raw   (lfsr_val[JIT_W-1:0]),
        .lfsr_step (lfsr_step),
        .mode_cur  (mode_cur),
        .trk_vhi   (trk_vhi),
        .trk_iout  (trk_iout),
        .trk_vlo   (trk_vlo),
        .trk_dv    (trk_dv),
        .soft_req  (soft_req)
    );

    dps_sync_div u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_tick),
        .sync_clk (sync_clk)
    );
endmodule

// File: tb/tb_dither_phase_seq.sv
module tb_dither_phase_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       spread_en = 1'b0;
    logic       run_ok = 1'b0;
    logic       ovp = 1'b0;
    logic       mode_cur, trk_vhi, trk_iout, trk_vlo, trk_dv, soft_req, sync_clk;
    logic [5:0] obs;

    int errs = 0;
    int checks = 0;
    logic [1:0]  tcnt = 2'd0;
    logic        mon_en = 1'b0;
    logic [9:0]  exq[$];
    logic [9:0]  item;
    logic [15:0] mlfsr;

    always #4 clk = ~clk;

    dither_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .div_sel(div_sel),
        .spread_en(spread_en), .run_ok(run_ok), .ovp(ovp), .mode_cur(mode_cur),
        .trk_vhi(trk_vhi), .trk_iout(trk_iout), .trk_vlo(trk_vlo), .trk_dv(trk_dv),
        .soft_req(soft_req), .sync_clk(sync_clk)
    );

    assign obs = {mode_cur, trk_vhi, trk_iout, trk_vlo, trk_dv, soft_req};

    always @(negedge clk) begin
        osc_tick <= (tcnt == 2'd3);
        tcnt     <= tcnt + 2'd1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: one expected item per tick interval
    always @(negedge clk) begin
        #1;
        if (mon_en && osc_tick) begin
            if (exq.size() == 0) begin
                chk(1'b0, "R2 unexpected tick", int'(obs), 0);
            end else begin
                item = exq.pop_front();
                chk(obs == item[5:0], $sformatf("R%0d", item[9:6]), int'(obs), int'(item[5:0]));
            end
        end
    end

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic push(input int tag, input logic [5:0] b);
        exq.push_back({4'(tag), b});
    endtask

    // R1 R3 R4: one full period of half length h
    task automatic push_period(input int h, input int tag0);
        for (int i = 0; i < h; i++)
            push((i == 0) ? tag0 : ((i == h - 1) ? 3 : 2), (i == h - 1) ? 6'b011000 : 6'b000000);
        for (int i = 0; i < h; i++)
            push((i >= h - 2) ? 4 : 2,
                 (i == h - 1) ? 6'b100010 : ((i == h - 2) ? 6'b100100 : 6'b100000));
    endtask

    // R6 R7: gap after a period end, then advance the model source
    task automatic push_gap(input int code, input bit spr);
        int cap, g;
        cap = (code >= 2) ? 3 : (1 << code);
        g   = spr ? ((int'(mlfsr[1:0]) > cap) ? cap : int'(mlfsr[1:0])) : 0;
        for (int i = 0; i < g; i++) push(7, 6'b000000);
        mlfsr = lfsr_next(mlfsr);
    endtask

    task automatic align();
        do begin
            @(negedge clk);
            #1;
        end while (!osc_tick);
        @(negedge clk);
    endtask

    task automatic wait_q(input int n);
        while (exq.size() > n) @(negedge clk);
    endtask

    task automatic start(input int code, input bit spr);
        div_sel   = 3'(code);
        spread_en = spr;
        align();
        run_ok = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        #2;
        chk(soft_req == 1'b1, "R9 soft pulse on run rise", int'(soft_req), 1);
    endtask

    task automatic stop();
        mon_en = 1'b0;
        run_ok = 1'b0;
        @(negedge clk);
        #2;
        chk(obs == 6'b0, "R8 idle after run drop", int'(obs), 0);
    endtask

    task automatic scenario(input int code, input bit spr, input int nper);
        mlfsr = 16'hACE1;
        for (int p = 0; p < nper; p++) begin
            if (p > 0) push_gap(code, spr);
            push_period(4 << code, (p == 0) ? 9 : (spr ? 1 : 6));
        end
        start(code, spr);
        wait_q(0);
        stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int bad;
        logic s0, s1;
        // R12 reset state
        repeat (3) @(negedge clk);
        #2;
        chk(obs == 6'b0, "R12 outputs in reset", int'(obs), 0);
        chk(sync_clk == 1'b0, "R12 sync low in reset", int'(sync_clk), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 sync toggles on each tick only
        for (int k = 0; k < 6; k++) begin
            do begin
                @(negedge clk);
                #1;
            end while (!osc_tick);
            s0 = sync_clk;
            @(negedge clk);
            #1;
            s1 = sync_clk;
            chk(s1 == !s0, "R11 toggle on tick", int'(s1), int'(!s0));
            @(negedge clk);
            #1;
            chk(sync_clk == s1, "R11 hold between ticks", int'(sync_clk), int'(s1));
        end

        // R8 ticks ignored while run is low
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            #2;
            if (obs != 6'b0) bad++;
        end
        chk(bad == 0, "R8 no activity with run low", bad, 0);

        scenario(0, 1'b0, 3);   // R1 R2 R3 R4 smallest half
        scenario(3, 1'b0, 2);
        scenario(7, 1'b0, 1);   // R1 largest half
        scenario(2, 1'b1, 8);   // R6 R7 cap 3

        // R8 run drop mid-period, then reseed shown by the next spread run
        push_period(16, 9);
        push_period(16, 6);
        start(2, 1'b0);
        wait_q(20);
        mon_en = 1'b0;
        run_ok = 1'b0;
        exq.delete();
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            #2;
            if (obs != 6'b0) bad++;
        end
        chk(bad == 0, "R8 forced idle mid-period", bad, 0);

        scenario(2, 1'b1, 4);   // R7 reseeded sequence
        scenario(0, 1'b1, 6);   // R6 cap 1
        scenario(1, 1'b1, 5);   // R6 cap 2

        // R5 divide code change mid-period
        push_period(8, 9);
        push_period(16, 5);
        push_period(16, 5);
        start(1, 1'b0);
        wait_q(72);
        div_sel = 3'd2;
        wait_q(0);
        stop();

        // R10 overvoltage block and R9 restart
        push_period(4, 9);
        start(0, 1'b0);
        wait_q(0);
        mon_en = 1'b0;
        ovp = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk(obs == 6'b0, "R10 blocked outputs", int'(obs), 0);
        bad = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            #2;
            if (obs != 6'b0) bad++;
        end
        chk(bad == 0, "R10 no strobes under ovp", bad, 0);
        push_period(4, 9);
        align();
        ovp = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        #2;
        chk(soft_req == 1'b1, "R9 soft pulse after ovp clears", int'(soft_req), 1);
        @(negedge clk);
        #2;
        chk(soft_req == 1'b0, "R9 pulse one clock", int'(soft_req), 0);
        wait_q(0);
        stop();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule